// File: doc/BRIEF.md
# Ternary fabric configuration loader

This block takes the configuration image of a ternary programmable fabric from an external microcontroller. The image arrives over an SPI slave link, and the block turns it into one write per configuration record for the grid's storage. The grid has columns and rows of logic blocks, and a horizontal routing channel for each row. Every logic block owns one 4-byte logic record. For each channel it also owns one 6-byte routing record, which holds twelve 4-bit switch selectors. A selector value of 0 leaves that switch open.

The SPI pins are oversampled in the system clock domain. Each byte that completes moves a byte pointer forward. From the pointer position the block derives three things: whether the current record is a logic record or a routing record, which column and row it belongs to, and which channel it addresses. When the last byte of a record arrives, the block presents the whole record on a registered write port for one cycle. A completion flag rises once the full image has been received. On the data-out pin the block echoes each received byte back during the byte that follows it, so the host can check the link.

Top module: `cfg_loader`

## Requirements
- R1: SPI mode 0 applies. MOSI is sampled on the rising edge of SCLK, and each byte is taken most significant bit first. Bits are counted only while chip select (active low) is asserted.
- R2: The image order is as follows. Columns go from 0 upward, and rows go from 0 upward within a column. For each (column, row) block there is one logic record, then one routing record per channel, channels 0 to N_ROWS-1 in order.
- R3: A completed logic record gives a one-cycle `cfg_lb_we` pulse with `cfg_col`/`cfg_row` set and `cfg_chan` = 0. The record's first byte is in `cfg_data[7:0]`, and each later byte is 8 bits higher. `cfg_data[47:32]` = 0.
- R4: A completed routing record gives a one-cycle `cfg_ic_we` pulse with `cfg_col`, `cfg_row` and `cfg_chan` (always below N_ROWS). Switch k is in `cfg_data[4k+3:4k]`, so switch 0 is the low nibble of the record's first byte.
- R5: The write outputs change only when a record completes. Between completions `cfg_data`, `cfg_col`, `cfg_row` and `cfg_chan` hold their values, and at most one write strobe is high in any cycle.
- R6: `load_done` rises in the same cycle as the strobe of the final record, after exactly N_COLS·N_ROWS·(4 + 6·N_ROWS) bytes. It is low before that point.
- R7: Once `load_done` is high, further bytes give no strobe and leave the outputs unchanged. `load_done` stays high through chip-select release, and it clears when chip select is next asserted.
- R8: If chip select is released before the full length has arrived, the load is aborted and `load_done` stays low. The next assertion of chip select restarts at the logic record of column 0, row 0.
- R9: While byte n (n ≥ 1) of a selection is clocked in, MISO shifts out byte n-1, most significant bit first, and is valid before each rising SCLK edge. During byte 0, MISO reads 0.
- R10: While reset is high (synchronous, active high), both strobes, `load_done`, `cfg_data` and MISO are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SPI pins are sampled with it |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host (echo of the previous byte) |
| cfg_lb_we | output | 1 | One-cycle write strobe for a logic record |
| cfg_ic_we | output | 1 | One-cycle write strobe for a routing record |
| cfg_col | output | idx_w(N_COLS) | Column of the written record |
| cfg_row | output | idx_w(N_ROWS) | Row of the written record |
| cfg_chan | output | idx_w(N_ROWS) | Channel of a routing record, 0 for a logic record |
| cfg_data | output | 48 | Record contents, first byte lowest |
| load_done | output | 1 | Full image received |

## Verification
The final routing record's write and the rise of `load_done` happen in the same cycle, and an extra byte can land just after that cycle. The bench sends exactly the full image for a small 2×2 grid and checks three things: `load_done` is still low after the second-to-last byte, the final record appears with the correct contents, and the flag is high afterwards. Three more bytes are then sent, and the bench checks that they produce no strobe and leave the flag set. A second collision is a chip-select release in the middle of a record. The bench releases the select two bytes into a record, then checks that `load_done` stays low and that the next selection writes column 0, row 0 first.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;
  localparam int LB_BYTES  = 4;   // logic record length
  localparam int IC_BYTES  = 6;   // routing record length
  localparam int SW_BITS   = 4;   // selector width per switch
  localparam int REC_BITS  = IC_BYTES * 8;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int group_bytes(input int rows);
    return LB_BYTES + rows * IC_BYTES;
  endfunction
endpackage

// File: rtl/spi_byte_rx.sv
`timescale 1ns/1ps
module spi_byte_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       sel_start,
  output logic       sel_end,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       sdo
);
  // pin order {sclk, cs_n, mosi}; idle levels used as reset values
  localparam logic [2:0] IDLE = 3'b010;

  logic [2:0] raw, synced;
  assign raw = {sclk, cs_n, mosi};

  for (genvar gi = 0; gi < 3; gi++) begin : g_sync
    logic [1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= {2{IDLE[gi]}};
      else     pipe <= {pipe[0], raw[gi]};
    end
    assign synced[gi] = pipe[1];
  end

  logic sclk_s, cs_s, mosi_s;
  assign sclk_s = synced[2];
  assign cs_s   = synced[1];
  assign mosi_s = synced[0];

  logic       sclk_q, cs_q;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic [7:0] tx;
  logic       rise, fall;

  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;
  assign sdo  = tx[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      bit_cnt   <= '0;
      shreg     <= '0;
      tx        <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      sel_start <= 1'b0;
      sel_end   <= 1'b0;
    end else begin
      sclk_q    <= sclk_s;
      cs_q      <= cs_s;
      byte_vld  <= 1'b0;
      sel_start <= cs_q & ~cs_s;
      sel_end   <= ~cs_q & cs_s;
      if (cs_q && !cs_s) begin
        bit_cnt <= '0;
        tx      <= '0;
      end else if (!cs_s) begin
        if (rise) begin
          shreg   <= {shreg[5:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_vld  <= 1'b1;
            byte_data <= {shreg, mosi_s};
            tx        <= {shreg, mosi_s};
          end
        end else if (fall && bit_cnt != 3'd0) begin
          tx <= {tx[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/cfg_seq.sv
`timescale 1ns/1ps
module cfg_seq
  import cfg_loader_pkg::*;
#(
  parameter int N_COLS = 7,
  parameter int N_ROWS = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sel_start,
  input  logic                      sel_end,
  input  logic                      byte_vld,
  input  logic [7:0]                byte_data,
  output logic                      lb_we,
  output logic                      ic_we,
  output logic [idx_w(N_COLS)-1:0]  col_o,
  output logic [idx_w(N_ROWS)-1:0]  row_o,
  output logic [idx_w(N_ROWS)-1:0]  chan_o,
  output logic [REC_BITS-1:0]       data_o,
  output logic                      done
);
  localparam int COL_W = idx_w(N_COLS);
  localparam int ROW_W = idx_w(N_ROWS);
  localparam int RI_W  = idx_w(N_ROWS + 1);
  localparam int TOTAL = N_COLS * N_ROWS * group_bytes(N_ROWS);
  localparam int PTR_W = $clog2(TOTAL + 1);

  logic [PTR_W-1:0]      ptr;
  logic [COL_W-1:0]      col;
  logic [ROW_W-1:0]      row;
  logic [RI_W-1:0]       rec;     // 0 = logic record, k = channel k-1
  logic [2:0]            bidx;
  logic [REC_BITS-9:0]   gather;
  logic                  active;
  logic                  rec_end;

  assign rec_end = (rec == '0) ? (bidx == 3'(LB_BYTES - 1))
                               : (bidx == 3'(IC_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0; col <= '0; row <= '0; rec <= '0; bidx <= '0;
      gather <= '0; active <= 1'b0; done <= 1'b0;
      lb_we <= 1'b0; ic_we <= 1'b0;
      col_o <= '0; row_o <= '0; chan_o <= '0; data_o <= '0;
    end else begin
      lb_we <= 1'b0;
      ic_we <= 1'b0;
      if (sel_start) begin
        ptr <= '0; col <= '0; row <= '0; rec <= '0; bidx <= '0;
        active <= 1'b1;
        done   <= 1'b0;
      end else if (sel_end) begin
        active <= 1'b0;
      end else if (byte_vld && active && !done) begin
        ptr <= ptr + 1'b1;
        if (!rec_end) begin
          gather[{bidx, 3'b000} +: 8] <= byte_data;
          bidx <= bidx + 3'd1;
        end else begin
          bidx  <= '0;
          col_o <= col;
          row_o <= row;
          if (rec == '0) begin
            lb_we  <= 1'b1;
            chan_o <= '0;
            data_o <= {16'h0000, byte_data, gather[23:0]};
          end else begin
            ic_we  <= 1'b1;
            chan_o <= ROW_W'(rec - 1'b1);
            data_o <= {byte_data, gather};
          end
          if (rec == RI_W'(N_ROWS)) begin
            rec <= '0;
            if (row == ROW_W'(N_ROWS - 1)) begin
              row <= '0;
              col <= col + 1'b1;
            end else begin
              row <= row + 1'b1;
            end
          end else begin
            rec <= rec + 1'b1;
          end
          if (ptr == PTR_W'(TOTAL - 1)) done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_loader.sv
`timescale 1ns/1ps
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int N_COLS = 7,
  parameter int N_ROWS = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      spi_sclk,
  input  logic                      spi_cs_n,
  input  logic                      spi_mosi,
  output logic                      spi_miso,
  output logic                      cfg_lb_we,
  output logic                      cfg_ic_we,
  output logic [idx_w(N_COLS)-1:0]  cfg_col,
  output logic [idx_w(N_ROWS)-1:0]  cfg_row,
  output logic [idx_w(N_ROWS)-1:0]  cfg_chan,
  output logic [REC_BITS-1:0]       cfg_data,
  output logic                      load_done
);
  logic       sel_start, sel_end, rx_vld;
  logic [7:0] rx_byte;

  spi_byte_rx u_rx (
    .clk       (clk),
    .rst       (rst),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .sel_start (sel_start),
    .sel_end   (sel_end),
    .byte_vld  (rx_vld),
    .byte_data (rx_byte),
    .sdo       (spi_miso)
  );

  cfg_seq #(.N_COLS(N_COLS), .N_ROWS(N_ROWS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .sel_start (sel_start),
    .sel_end   (sel_end),
    .byte_vld  (rx_vld),
    .byte_data (rx_byte),
    .lb_we     (cfg_lb_we),
    .ic_we     (cfg_ic_we),
    .col_o     (cfg_col),
    .row_o     (cfg_row),
    .chan_o    (cfg_chan),
    .data_o    (cfg_data),
    .done      (load_done)
  );
endmodule

// File: rtl/cfg_loader_chk.sv
`timescale 1ns/1ps
module cfg_loader_chk
  import cfg_loader_pkg::*;
#(
  parameter int N_COLS = 7,
  parameter int N_ROWS = 9
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      sel_start,
  input logic                      sel_end,
  input logic                      lb_we,
  input logic                      ic_we,
  input logic [idx_w(N_COLS)-1:0]  col,
  input logic [idx_w(N_ROWS)-1:0]  row,
  input logic [idx_w(N_ROWS)-1:0]  chan,
  input logic [REC_BITS-1:0]       data,
  input logic                      done,
  input logic                      miso
);
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lb_we, ic_we}));

  p_hold_outputs_r5: assert property (@(posedge clk) disable iff (rst)
    !(lb_we || ic_we) |-> ($stable(data) && $stable(col) && $stable(row) && $stable(chan)));

  p_chan_range_r4: assert property (@(posedge clk) disable iff (rst)
    ic_we |-> (int'(chan) < N_ROWS));

  p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (rst)
    $past(done) |-> !(lb_we || ic_we));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !sel_start) |=> done);

  p_abort_keeps_low_r8: assert property (@(posedge clk) disable iff (rst)
    (sel_end && !done) |=> !done);

  p_miso_clear_at_select_r9: assert property (@(posedge clk) disable iff (rst)
    sel_start |-> !miso);
endmodule

bind cfg_loader cfg_loader_chk #(.N_COLS(N_COLS), .N_ROWS(N_ROWS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sel_start (sel_start),
  .sel_end   (sel_end),
  .lb_we     (cfg_lb_we),
  .ic_we     (cfg_ic_we),
  .col       (cfg_col),
  .row       (cfg_row),
  .chan      (cfg_chan),
  .data      (cfg_data),
  .done      (load_done),
  .miso      (spi_miso)
);

// File: tb/cfg_loader_bench.sv
`timescale 1ns/1ps
module cfg_loader_bench;
  localparam int NC   = 2;
  localparam int NR   = 2;
  localparam int GRP  = 4 + 6 * NR;
  localparam int TOT  = NC * NR * GRP;
  localparam int NREC = NC * NR * (NR + 1);
  localparam int HALF = 6;
  // tag: bit7 = routing record, [5:4] col, [3:2] row, [1:0] chan
  localparam logic [7:0] REC_TAB [0:NREC-1] = '{
    8'h00, 8'h80, 8'h81, 8'h04, 8'h84, 8'h85,
    8'h10, 8'h90, 8'h91, 8'h14, 8'h94, 8'h95};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso, cfg_lb_we, cfg_ic_we, load_done;
  logic [0:0]  cfg_col, cfg_row, cfg_chan;
  logic [47:0] cfg_data;

  int checks = 0;
  int fails  = 0;
  int cap_n  = 0;
  logic [7:0]  cap_tag  [0:63];
  logic [47:0] cap_data [0:63];

  always #5 clk = ~clk;

  cfg_loader #(.N_COLS(NC), .N_ROWS(NR)) u_cfg_loader (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .cfg_lb_we(cfg_lb_we),
    .cfg_ic_we(cfg_ic_we), .cfg_col(cfg_col), .cfg_row(cfg_row),
    .cfg_chan(cfg_chan), .cfg_data(cfg_data), .load_done(load_done));

  always @(negedge clk) begin
    if (!rst && (cfg_lb_we || cfg_ic_we) && cap_n < 64) begin
      cap_tag[cap_n]  <= {cfg_ic_we, 1'b0, 2'(cfg_col), 2'(cfg_row), 2'(cfg_chan)};
      cap_data[cap_n] <= cfg_data;
      cap_n <= cap_n + 1;
    end
  end

  function automatic logic [7:0] pat(input int p);
    return 8'(p * 29 + 7);
  endfunction

  function automatic logic [47:0] rec_val(input int off, input bit ic);
    logic [47:0] v = '0;
    for (int k = 0; k < (ic ? 6 : 4); k++) v[k*8 +: 8] = pat(off + k);
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = b[i];
      repeat (HALF) @(posedge clk);
      #1 got[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(posedge clk);
      #1 spi_sclk = 1'b0;
    end
  endtask

  task automatic select(input bit on);
    repeat (HALF) @(posedge clk);
    #1 spi_cs_n = !on;
    repeat (HALF) @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] got;
    int n0, off;
    logic [47:0] held;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 reset outputs", 64'({cfg_lb_we, cfg_ic_we, load_done, spi_miso, cfg_data}), 64'h0);
    #1 rst = 1'b0;

    // full image, with readback of the previous byte
    select(1'b1);
    for (int p = 0; p < TOT; p++) begin
      spi_byte(pat(p), got);
      chk("R9 miso echo", 64'(got), 64'((p == 0) ? 8'h00 : pat(p - 1)));
      if (p == TOT - 2) begin
        @(negedge clk);
        chk("R6 done low before last byte", 64'(load_done), 64'h0);
      end
    end
    @(negedge clk);
    chk("R6 done after full length", 64'(load_done), 64'h1);
    chk("R2 record count", 64'(cap_n), 64'(NREC));
    chk("R1 first byte MSB-first", 64'(cap_data[0][7:0]), 64'(pat(0)));
    off = 0;
    for (int r = 0; r < NREC; r++) begin
      chk("R2 record order", 64'(cap_tag[r]), 64'(REC_TAB[r]));
      if (REC_TAB[r][7]) chk("R4 routing record", 64'(cap_data[r]), 64'(rec_val(off, 1'b1)));
      else               chk("R3 logic record", 64'(cap_data[r]), 64'(rec_val(off, 1'b0)));
      off += REC_TAB[r][7] ? 6 : 4;
    end

    // bytes beyond the image
    n0 = cap_n;
    held = cfg_data;
    for (int p = 0; p < 3; p++) spi_byte(8'hA5 + 8'(p), got);
    @(negedge clk);
    chk("R7 no strobe after done", 64'(cap_n), 64'(n0));
    chk("R7 data held after done", 64'(cfg_data), 64'(held));
    chk("R7 done stays high", 64'(load_done), 64'h1);
    select(1'b0);
    chk("R7 done through release", 64'(load_done), 64'h1);
    select(1'b1);
    chk("R7 done cleared on select", 64'(load_done), 64'h0);

    // partial load then abort
    n0 = cap_n;
    for (int p = 0; p < 20; p++) spi_byte(pat(100 + p), got);
    @(negedge clk);
    chk("R8 partial strobes", 64'(cap_n), 64'(n0 + 4));
    chk("R2 second block logic tag", 64'(cap_tag[n0 + 3]), 64'h04);
    held = cfg_data;
    for (int p = 0; p < 2; p++) spi_byte(pat(120 + p), got);
    @(negedge clk);
    chk("R5 no strobe mid record", 64'(cap_n), 64'(n0 + 4));
    chk("R5 data held mid record", 64'(cfg_data), 64'(held));
    select(1'b0);
    chk("R8 abort leaves done low", 64'(load_done), 64'h0);
    select(1'b1);
    n0 = cap_n;
    for (int p = 0; p < 4; p++) spi_byte(pat(200 + p), got);
    @(negedge clk);
    chk("R8 restart strobe count", 64'(cap_n), 64'(n0 + 1));
    chk("R8 restart at origin", 64'(cap_tag[n0]), 64'h00);
    chk("R8 restart data", 64'(cap_data[n0]), 64'(rec_val(200, 1'b0)));
    select(1'b0);

    summary();
    $finish;
  end
endmodule